// File: doc/BRIEF.md
# Virtual-Machine Integer ALU

This block is the integer execute stage of a 64-bit register virtual machine used for packet filtering. It takes an already decoded arithmetic instruction (a 4-bit operation code, a width mode, a choice between a register operand and a 32-bit immediate, and the instruction's 16-bit offset field) together with the current destination and source register values. It produces the value that is written back to the destination register. The block is purely combinational and has no clock.

The offset field selects the signed divide and modulo variants and the sign-extending move. In the 32-bit mode the operands are cut to their low halves and the upper half of the result is cleared. Results for division and modulo by zero are fully defined, and signed overflow wraps without raising any exception. A byte-swap operation code is reported on its own flag and is not executed. Any other code and offset pair outside the listed set raises an illegal flag. In both cases the destination value passes through unchanged.

Top module: `vm_alu`

## Requirements
- R1: In 64-bit mode (wide_i=1), codes 0x0 add, 0x1 sub, 0x2 mul, 0x4 or, 0x5 and and 0xa xor combine dst and the source operand over 64 bits, and add, sub and mul wrap modulo 2^64.
- R2: In 32-bit mode (wide_i=0), every operation uses only the low 32 bits of dst and of the source operand, wraps modulo 2^32, and drives bits 63:32 of result_o to zero.
- R3: With use_imm_i=1 the source operand is imm_i. It is sign-extended to 64 bits in 64-bit mode or for signed divide and modulo, and zero-extended otherwise.
- R4: Code 0x3 is divide and code 0x9 is modulo. Offset 0 selects unsigned and offset 1 selects signed. Signed division truncates toward zero, so the signed remainder has the sign of the dividend.
- R5: Division by a zero source operand gives 0.
- R6: Modulo by a zero source operand returns dst unchanged in 64-bit mode. In 32-bit mode it returns the low 32 bits of dst with the upper 32 bits cleared.
- R7: Signed division of the most negative value by -1 gives the most negative value, and the matching signed modulo gives 0.
- R8: Code 0x6 is a left shift, 0x7 a logical right shift and 0xc an arithmetic right shift. The shift amount is the source operand masked with 0x3F in 64-bit mode and with 0x1F in 32-bit mode.
- R9: Code 0x8 gives the negation of dst. Code 0xb with offset 0 copies the source operand. With offset 8, 16 or 32 it sign-extends that many low bits of the source operand, and offset 32 is allowed only in 64-bit mode.
- R10: illegal_o is 1 and result_o equals dst_i for codes 0xe and 0xf, for an offset other than 0 or 1 on divide or modulo, for a move offset outside the allowed set, and for a nonzero offset on any other code.
- R11: Code 0xd (byte swap) sets unsupported_o to 1, keeps illegal_o at 0 and returns dst_i unchanged. unsupported_o and illegal_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code_i | input | 4 | Operation code (upper nibble of the opcode) |
| wide_i | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| use_imm_i | input | 1 | 1 selects imm_i as the source operand, 0 selects src_i |
| insn_off_i | input | 16 | Instruction offset field |
| imm_i | input | 32 | Immediate value |
| dst_i | input | 64 | Current destination register value |
| src_i | input | 64 | Source register value |
| result_o | output | 64 | Value to write back to the destination |
| illegal_o | output | 1 | Code and offset pair is not a valid operation |
| unsupported_o | output | 1 | Byte-swap code seen; not executed here |

## Verification
The hardest cases to reach are the signed overflow of the most negative dividend by -1 and the divide or modulo by zero. Random 64-bit operands almost never produce them, and each must also be reached through the immediate path, where a 32-bit all-ones value becomes -1 only after sign extension. The stimulus therefore covers these cases with directed vectors in both modes and from both source selections. It also biases the random operands toward zero, all-ones and the most negative value, and draws offsets from a weighted list so that the signed and sign-extending variants and the illegal pairs appear often.

// File: rtl/vm_alu_pkg.sv
package vm_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_MUL  = 4'h2, OP_DIV  = 4'h3,
    OP_OR   = 4'h4, OP_AND  = 4'h5, OP_LSH  = 4'h6, OP_RSH  = 4'h7,
    OP_NEG  = 4'h8, OP_MOD  = 4'h9, OP_XOR  = 4'ha, OP_MOV  = 4'hb,
    OP_ARSH = 4'hc, OP_SWAP = 4'hd, OP_RSVE = 4'he, OP_RSVF = 4'hf
  } vm_op_e;

  typedef enum logic [1:0] {SH_LEFT, SH_LOGIC, SH_ARITH} vm_shift_e;
endpackage

// File: rtl/vm_alu_opnd.sv
module vm_alu_opnd #(
  parameter int XLEN = 64,
  parameter int IMMW = 32
) (
  input  logic            wide_i,
  input  logic            use_imm_i,
  input  logic            imm_sext_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [IMMW-1:0] imm_i,
  output logic [XLEN-1:0] a_zx_o,
  output logic [XLEN-1:0] a_sx_o,
  output logic [XLEN-1:0] b_zx_o,
  output logic [XLEN-1:0] b_sx_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] b_raw;

  always_comb begin
    if (use_imm_i)
      b_raw = imm_sext_i ? {{(XLEN-IMMW){imm_i[IMMW-1]}}, imm_i}
                         : {{(XLEN-IMMW){1'b0}}, imm_i};
    else
      b_raw = src_i;
  end

  assign a_zx_o = wide_i ? dst_i : {{HALF{1'b0}}, dst_i[HALF-1:0]};
  assign a_sx_o = wide_i ? dst_i : {{HALF{dst_i[HALF-1]}}, dst_i[HALF-1:0]};
  assign b_zx_o = wide_i ? b_raw : {{HALF{1'b0}}, b_raw[HALF-1:0]};
  assign b_sx_o = wide_i ? b_raw : {{HALF{b_raw[HALF-1]}}, b_raw[HALF-1:0]};
endmodule

// File: rtl/vm_alu_divmod.sv
module vm_alu_divmod #(
  parameter int XLEN = 64
) (
  input  logic            signed_i,
  input  logic [XLEN-1:0] num_i,
  input  logic [XLEN-1:0] den_i,
  output logic [XLEN-1:0] quot_o,
  output logic [XLEN-1:0] rem_o
);
  logic den_zero, den_minus1;

  assign den_zero   = (den_i == '0);
  assign den_minus1 = (den_i == '1);

  always_comb begin
    if (den_zero) begin
      quot_o = '0;
      rem_o  = num_i;
    end else if (signed_i && den_minus1) begin
      // quotient is plain negation so the most negative value wraps to itself
      quot_o = -num_i;
      rem_o  = '0;
    end else if (signed_i) begin
      quot_o = $unsigned($signed(num_i) / $signed(den_i));
      rem_o  = $unsigned($signed(num_i) % $signed(den_i));
    end else begin
      quot_o = num_i / den_i;
      rem_o  = num_i % den_i;
    end
  end
endmodule

// File: rtl/vm_alu_shift.sv
module vm_alu_shift
  import vm_alu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  vm_shift_e       kind_i,
  input  logic [XLEN-1:0] val_zx_i,
  input  logic [XLEN-1:0] val_sx_i,
  input  logic [SHW-1:0]  amt_i,
  output logic [XLEN-1:0] out_o
);
  always_comb begin
    case (kind_i)
      SH_LEFT:  out_o = val_zx_i << amt_i;
      SH_ARITH: out_o = $unsigned($signed(val_sx_i) >>> amt_i);
      default:  out_o = val_zx_i >> amt_i;
    endcase
  end
endmodule

// File: rtl/vm_alu.sv
module vm_alu
  import vm_alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 32,
  parameter int OFFW = 16
) (
  input  logic [3:0]      op_code_i,
  input  logic            wide_i,
  input  logic            use_imm_i,
  input  logic [OFFW-1:0] insn_off_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [XLEN-1:0] src_i,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o,
  output logic            unsupported_o
);
  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);

  vm_op_e          op;
  logic            off_zero, off_one, signed_op, legal;
  logic [XLEN-1:0] a_zx, a_sx, b_zx, b_sx;
  logic [XLEN-1:0] quot, rem, shifted, movsx, raw;
  logic [SHW-1:0]  amt;
  vm_shift_e       sh_kind;

  assign op        = vm_op_e'(op_code_i);
  assign off_zero  = (insn_off_i == OFFW'(0));
  assign off_one   = (insn_off_i == OFFW'(1));
  assign signed_op = ((op == OP_DIV) || (op == OP_MOD)) && off_one;

  always_comb begin
    case (op)
      OP_DIV, OP_MOD: legal = off_zero || off_one;
      OP_MOV:         legal = off_zero || (insn_off_i == OFFW'(8)) ||
                              (insn_off_i == OFFW'(16)) ||
                              ((insn_off_i == OFFW'(HALF)) && wide_i);
      OP_SWAP:        legal = 1'b1;
      OP_RSVE, OP_RSVF: legal = 1'b0;
      default:        legal = off_zero;
    endcase
  end

  vm_alu_opnd #(.XLEN(XLEN), .IMMW(IMMW)) opnd_i (
    .wide_i(wide_i), .use_imm_i(use_imm_i), .imm_sext_i(wide_i | signed_op),
    .dst_i(dst_i), .src_i(src_i), .imm_i(imm_i),
    .a_zx_o(a_zx), .a_sx_o(a_sx), .b_zx_o(b_zx), .b_sx_o(b_sx)
  );

  vm_alu_divmod #(.XLEN(XLEN)) div_i (
    .signed_i(signed_op),
    .num_i(signed_op ? a_sx : a_zx),
    .den_i(signed_op ? b_sx : b_zx),
    .quot_o(quot), .rem_o(rem)
  );

  assign amt = wide_i ? b_zx[SHW-1:0] : {1'b0, b_zx[SHW-2:0]};

  always_comb begin
    case (op)
      OP_LSH:  sh_kind = SH_LEFT;
      OP_ARSH: sh_kind = SH_ARITH;
      default: sh_kind = SH_LOGIC;
    endcase
  end

  vm_alu_shift #(.XLEN(XLEN)) shf_i (
    .kind_i(sh_kind), .val_zx_i(a_zx), .val_sx_i(a_sx),
    .amt_i(amt), .out_o(shifted)
  );

  // sign-extend the low "offset" bits of the source operand
  always_comb begin
    movsx = b_zx;
    for (int i = 0; i < XLEN; i++) begin
      if (insn_off_i == OFFW'(8))
        movsx[i] = (i < 8) ? b_zx[i] : b_zx[7];
      else if (insn_off_i == OFFW'(16))
        movsx[i] = (i < 16) ? b_zx[i] : b_zx[15];
      else if (insn_off_i == OFFW'(HALF))
        movsx[i] = (i < HALF) ? b_zx[i] : b_zx[HALF-1];
    end
  end

  always_comb begin
    case (op)
      OP_ADD:  raw = a_zx + b_zx;
      OP_SUB:  raw = a_zx - b_zx;
      OP_MUL:  raw = a_zx * b_zx;
      OP_DIV:  raw = quot;
      OP_OR:   raw = a_zx | b_zx;
      OP_AND:  raw = a_zx & b_zx;
      OP_NEG:  raw = -a_zx;
      OP_MOD:  raw = rem;
      OP_XOR:  raw = a_zx ^ b_zx;
      OP_MOV:  raw = off_zero ? b_zx : movsx;
      OP_LSH, OP_RSH, OP_ARSH: raw = shifted;
      default: raw = dst_i;
    endcase
  end

  assign unsupported_o = (op == OP_SWAP);
  assign illegal_o     = !legal;

  always_comb begin
    if (illegal_o || unsupported_o)
      result_o = dst_i;
    else if (wide_i)
      result_o = raw;
    else
      result_o = {{HALF{1'b0}}, raw[HALF-1:0]};
  end
endmodule

// File: rtl/vm_alu_chk.sv
module vm_alu_chk #(
  parameter int XLEN = 64,
  parameter int IMMW = 32,
  parameter int OFFW = 16
) (
  input logic [3:0]      op_code_i,
  input logic            wide_i,
  input logic            use_imm_i,
  input logic [OFFW-1:0] insn_off_i,
  input logic [IMMW-1:0] imm_i,
  input logic [XLEN-1:0] dst_i,
  input logic [XLEN-1:0] src_i,
  input logic [XLEN-1:0] result_o,
  input logic            illegal_o,
  input logic            unsupported_o
);
  localparam int HALF = XLEN / 2;

  logic src_zero;
  assign src_zero = use_imm_i ? (imm_i == '0)
                  : (wide_i ? (src_i == '0) : (src_i[HALF-1:0] == '0));

  always_comb begin
    if (illegal_o)
      assert_illegal_keeps_dst_R10: assert (result_o == dst_i)
        else $error("illegal op altered result");
    if (unsupported_o)
      assert_swap_keeps_dst_R11: assert (result_o == dst_i && !illegal_o)
        else $error("byte swap not passed through");
    assert_flags_exclusive_R11: assert ($onehot0({illegal_o, unsupported_o}))
      else $error("both flags high");
    if (!wide_i && !illegal_o && !unsupported_o)
      assert_upper_clear_R2: assert (result_o[XLEN-1:HALF] == '0)
        else $error("upper half not cleared in 32-bit mode");
    if (op_code_i == 4'h3 && !illegal_o && src_zero)
      assert_div_zero_R5: assert (result_o == '0)
        else $error("divide by zero result not zero");
    if (op_code_i == 4'h9 && wide_i && !illegal_o && src_zero)
      assert_mod_zero_R6: assert (result_o == dst_i)
        else $error("modulo by zero changed dst");
  end
endmodule

bind vm_alu vm_alu_chk #(.XLEN(XLEN), .IMMW(IMMW), .OFFW(OFFW)) chk_i (
  .op_code_i(op_code_i), .wide_i(wide_i), .use_imm_i(use_imm_i),
  .insn_off_i(insn_off_i), .imm_i(imm_i), .dst_i(dst_i), .src_i(src_i),
  .result_o(result_o), .illegal_o(illegal_o), .unsupported_o(unsupported_o)
);

// File: tb/vm_alu_tb_top.sv
module vm_alu_tb_top;
  logic        clk = 1'b0;
  logic [3:0]  op;
  logic        wide, uimm;
  logic [15:0] off;
  logic [31:0] imm;
  logic [63:0] dst, src;
  logic [63:0] res;
  logic        ill, uns;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  vm_alu dut_i (
    .op_code_i(op), .wide_i(wide), .use_imm_i(uimm), .insn_off_i(off),
    .imm_i(imm), .dst_i(dst), .src_i(src),
    .result_o(res), .illegal_o(ill), .unsupported_o(uns)
  );

  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

  function automatic logic [65:0] model(input logic [3:0] o, input logic w, input logic u,
      input logic [15:0] f, input logic [31:0] im, input logic [63:0] d, input logic [63:0] s);
    logic ok, sg;
    logic [63:0] b, r;
    logic [31:0] a3, b3, r3;
    if (o == 4'hd) return {2'b01, d};
    if (o == 4'h3 || o == 4'h9) ok = (f == 0 || f == 1);
    else if (o == 4'hb) ok = (f == 0 || f == 8 || f == 16 || (f == 32 && w));
    else if (o >= 4'he) ok = 1'b0;
    else ok = (f == 0);
    if (!ok) return {2'b10, d};
    sg = (o == 4'h3 || o == 4'h9) && f == 1;
    b = u ? ((w || sg) ? {{32{im[31]}}, im} : {32'd0, im}) : s;
    if (w) begin
      case (o)
        4'h0: r = d + b;
        4'h1: r = d - b;
        4'h2: r = d * b;
        4'h3: r = (b == 0) ? 64'd0 : !sg ? d / b :
                  (b == '1) ? (0 - d) : $unsigned($signed(d) / $signed(b));
        4'h4: r = d | b;
        4'h5: r = d & b;
        4'h6: r = d << b[5:0];
        4'h7: r = d >> b[5:0];
        4'h8: r = 0 - d;
        4'h9: r = (b == 0) ? d : !sg ? d % b :
                  (b == '1) ? 64'd0 : $unsigned($signed(d) % $signed(b));
        4'ha: r = d ^ b;
        4'hb: r = (f == 8) ? {{56{b[7]}}, b[7:0]} : (f == 16) ? {{48{b[15]}}, b[15:0]} :
                  (f == 32) ? {{32{b[31]}}, b[31:0]} : b;
        default: r = $unsigned($signed(d) >>> b[5:0]);
      endcase
    end else begin
      a3 = d[31:0]; b3 = b[31:0];
      case (o)
        4'h0: r3 = a3 + b3;
        4'h1: r3 = a3 - b3;
        4'h2: r3 = a3 * b3;
        4'h3: r3 = (b3 == 0) ? 32'd0 : !sg ? a3 / b3 :
                   (b3 == '1) ? (0 - a3) : $unsigned($signed(a3) / $signed(b3));
        4'h4: r3 = a3 | b3;
        4'h5: r3 = a3 & b3;
        4'h6: r3 = a3 << b3[4:0];
        4'h7: r3 = a3 >> b3[4:0];
        4'h8: r3 = 0 - a3;
        4'h9: r3 = (b3 == 0) ? a3 : !sg ? a3 % b3 :
                   (b3 == '1) ? 32'd0 : $unsigned($signed(a3) % $signed(b3));
        4'ha: r3 = a3 ^ b3;
        4'hb: r3 = (f == 8) ? {{24{b3[7]}}, b3[7:0]} : (f == 16) ? {{16{b3[15]}}, b3[15:0]} : b3;
        default: r3 = $unsigned($signed(a3) >>> b3[4:0]);
      endcase
      r = {32'd0, r3};
    end
    return {2'b00, r};
  endfunction

  task automatic check(input string tag, input logic [3:0] o, input logic w, input logic u,
      input logic [15:0] f, input logic [31:0] im, input logic [63:0] d, input logic [63:0] s);
    logic [65:0] exp;
    @(negedge clk);
    op = o; wide = w; uimm = u; off = f; imm = im; dst = d; src = s;
    #2;
    exp = model(o, w, u, f, im, d, s);
    n_run++;
    if ({ill, uns, res} !== exp) begin
      n_fail++;
      $display("FAIL %s op=%h w=%0d imm=%0d off=%0d: got ill=%0d uns=%0d res=%h, exp ill=%0d uns=%0d res=%h",
               tag, o, w, u, f, ill, uns, res, exp[65], exp[64], exp[63:0]);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o, input logic w, input logic [15:0] f);
    logic [65:0] e;
    e = model(o, w, 1'b0, f, 32'd0, 64'd0, 64'd0);
    if (e[64]) return "R11";
    if (e[65]) return "R10";
    if (o == 4'h3 || o == 4'h9) return "R4";
    if (o == 4'h6 || o == 4'h7 || o == 4'hc) return "R8";
    if (o == 4'h8 || o == 4'hb) return "R9";
    return w ? "R1" : "R2";
  endfunction

  function automatic logic [63:0] pick64();
    case ($urandom % 8)
      0: return 64'd0;
      1: return '1;
      2: return MIN64;
      3: return {32'd0, $urandom};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic run_all();
    // idle pattern: all-zero add
    check("R1", 4'h0, 1'b1, 1'b0, 16'd0, 32'd0, 64'd0, 64'd0);
    // R1: wrap and logic ops
    check("R1", 4'h0, 1'b1, 1'b0, 16'd0, 32'd0, '1, 64'd2);
    check("R1", 4'h2, 1'b1, 1'b0, 16'd0, 32'd0, 64'h1_0000_0001, 64'hFFFF_FFFF_0000_0003);
    check("R1", 4'ha, 1'b1, 1'b0, 16'd0, 32'd0, 64'hF0F0, 64'h0FF0);
    // R2: 32-bit truncation
    check("R2", 4'h0, 1'b0, 1'b0, 16'd0, 32'd0, 64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_0000_0001);
    check("R2", 4'h1, 1'b0, 1'b0, 16'd0, 32'd0, 64'h1234_0000_0000, 64'd1);
    // R3: immediate extension
    check("R3", 4'h0, 1'b1, 1'b1, 16'd0, 32'hFFFF_FFFF, 64'd5, 64'd0);
    check("R3", 4'h3, 1'b1, 1'b1, 16'd0, 32'hFFFF_FFFF, '1, 64'd0);
    check("R3", 4'h3, 1'b0, 1'b1, 16'd1, 32'hFFFF_FFFE, 64'd100, 64'd0);
    // R4: signed truncation, remainder sign
    check("R4", 4'h3, 1'b1, 1'b0, 16'd1, 32'd0, -64'sd7, 64'd2);
    check("R4", 4'h9, 1'b1, 1'b0, 16'd1, 32'd0, -64'sd7, 64'd2);
    check("R4", 4'h9, 1'b0, 1'b0, 16'd1, 32'd0, 64'd7, 64'hFFFF_FFFE);
    check("R4", 4'h3, 1'b1, 1'b0, 16'd0, 32'd0, '1, 64'd16);
    // R5 / R6: zero divisor
    check("R5", 4'h3, 1'b1, 1'b0, 16'd1, 32'd0, 64'd99, 64'd0);
    check("R5", 4'h3, 1'b0, 1'b0, 16'd0, 32'd0, 64'd99, 64'h7_0000_0000);
    check("R6", 4'h9, 1'b1, 1'b1, 16'd1, 32'd0, 64'hDEAD_BEEF_1234_5678, 64'd0);
    check("R6", 4'h9, 1'b0, 1'b0, 16'd0, 32'd0, 64'hDEAD_BEEF_1234_5678, 64'h1_0000_0000);
    // R7: overflow
    check("R7", 4'h3, 1'b1, 1'b0, 16'd1, 32'd0, MIN64, '1);
    check("R7", 4'h9, 1'b1, 1'b1, 16'd1, 32'hFFFF_FFFF, MIN64, 64'd0);
    check("R7", 4'h3, 1'b0, 1'b1, 16'd1, 32'hFFFF_FFFF, 64'h8000_0000, 64'd0);
    // R8: shift masking
    check("R8", 4'h6, 1'b1, 1'b0, 16'd0, 32'd0, 64'd1, 64'd65);
    check("R8", 4'h7, 1'b0, 1'b0, 16'd0, 32'd0, 64'h8000_0000, 64'd33);
    check("R8", 4'hc, 1'b0, 1'b0, 16'd0, 32'd0, 64'h8000_0000, 64'd4);
    check("R8", 4'hc, 1'b1, 1'b0, 16'd0, 32'd0, MIN64, 64'd63);
    // R9: neg, mov, movsx
    check("R9", 4'h8, 1'b1, 1'b0, 16'd0, 32'd0, 64'd1, 64'd0);
    check("R9", 4'hb, 1'b1, 1'b0, 16'd8, 32'd0, 64'd0, 64'h80);
    check("R9", 4'hb, 1'b0, 1'b0, 16'd16, 32'd0, 64'd0, 64'h8000);
    check("R9", 4'hb, 1'b1, 1'b0, 16'd32, 32'd0, 64'd0, 64'h8000_0000);
    // R10: illegal pairs
    check("R10", 4'hb, 1'b0, 1'b0, 16'd32, 32'd0, 64'h55, 64'h8000_0000);
    check("R10", 4'h3, 1'b1, 1'b0, 16'd2, 32'd0, 64'h77, 64'd3);
    check("R10", 4'hf, 1'b1, 1'b0, 16'd0, 32'd0, 64'h99, 64'd3);
    check("R10", 4'h0, 1'b1, 1'b0, 16'd1, 32'd0, 64'h99, 64'd3);
    // R11: byte swap flagged
    check("R11", 4'hd, 1'b0, 1'b1, 16'd0, 32'd16, 64'h1122_3344_5566_7788, 64'd0);
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  o;
      logic        w;
      logic [15:0] f;
      o = 4'($urandom);
      w = 1'($urandom);
      case ($urandom % 8)
        0, 1, 2: f = 16'd0;
        3: f = 16'd1;
        4: f = 16'd8;
        5: f = 16'd16;
        6: f = 16'd32;
        default: f = 16'($urandom);
      endcase
      check(tag_of(o, w, f), o, w, 1'($urandom), f,
            ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom, pick64(), pick64());
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    op = 4'h0; wide = 1'b1; uimm = 1'b0; off = 16'd0; imm = 32'd0; dst = 64'd0; src = 64'd0;
    fork
      begin run_all(); done = 1'b1; end
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          n_run++; n_fail++;
          $display("FAIL watchdog: got timeout, exp completion");
        end
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule